// File: doc/BRIEF.md
# PHY Polling Unit Access Arbiter

This controller sits between an autonomous PHY polling unit and a host that now and then needs direct access to PHY registers. The polling unit and the host must not use the management bus at the same time. When the host asks for access, the arbiter switches the polling unit off and waits for the unit to report that it has stopped. Only then does it grant the access. If the unit does not stop in time, the request is refused.

The unit is switched back on lazily. When an access ends, a hold-off timer measured in millisecond ticks starts. It restarts after every later access. A request that arrives while the unit is still held off cancels the timer and is granted in the next cycle, with no new stop handshake. When the timer runs out, the arbiter turns the unit on and waits for it to report active. If the unit does not report active in time, the arbiter raises an error and keeps the unit marked as off.

Every wait is bounded. The unit's state is sampled once per millisecond tick, for at most a set number of ticks, and then the wait ends with a timeout.

Top module: `phy_poll_arbiter`

## Requirements
- R1: After reset `poll_en` is 1, `host_grant` is 0 and `host_err` is 0. While the unit is enabled and no request is pending, millisecond ticks change none of these outputs.
- R2: A request to an enabled unit clears `poll_en` in the next cycle. `host_grant` rises only after a tick at which `poll_state` is not 2'b11. The value 2'b11 means the unit is active.
- R3: `host_grant` is never 1 while `poll_en` is 1. Once raised, `host_grant` stays 1 until a cycle with `host_done` high.
- R4: If `poll_state` still reads 2'b11 at each of `WAIT_LIMIT` ticks of a stop wait, the request is refused. `host_err` goes to 1, `host_grant` stays 0 and `poll_en` returns to 1. `host_err` holds until `host_req` falls, and the unit is then idle and enabled.
- R5: After `host_done`, `poll_en` stays 0 through the next `HOLDOFF_MS - 1` ticks. It rises in the cycle after the `HOLDOFF_MS`-th tick.
- R6: A request during the hold-off is granted in the next cycle, and `poll_en` stays 0. Ticks seen during that access do not end the hold-off. The full `HOLDOFF_MS` count restarts from its next `host_done`.
- R7: A start wait completes at the first tick with `poll_state` equal to 2'b11. The unit then counts as enabled, so the next request goes through the stop handshake of R2.
- R8: If `poll_state` is not 2'b11 at each of `WAIT_LIMIT` ticks of a start wait, `host_err` pulses for one cycle and `poll_en` returns to 0. The unit stays marked as disabled, so the next request is granted in the next cycle.
- R9: A request raised during a start wait gets no grant and leaves `poll_en` at 1 until that wait succeeds. It is then served with the stop handshake of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host asks for PHY access. Held high until `host_done` or until refused. |
| host_done | input | 1 | One-cycle pulse ending the granted access |
| host_grant | output | 1 | Access granted. The polling unit is off. |
| host_err | output | 1 | Stop wait refused (level) or start wait timed out (pulse) |
| poll_en | output | 1 | Enable for the polling unit |
| poll_state | input | 2 | Polling unit state. 2'b11 means active. |
| ms_tick | input | 1 | One-cycle pulse every millisecond |

## Verification
The bench builds the block with `WAIT_LIMIT = 4` and `HOLDOFF_MS = 3`. With these values every length of stop wait and start wait can be swept, from success at the first tick up to timeout at the last tick. It can also place a fresh request at every tick position inside the hold-off window. All expected grant, enable and error timing is derived from the two parameter values.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;
  localparam logic [1:0] POLL_ACTIVE = 2'b11;

  typedef enum logic [2:0] {
    ST_LIVE,
    ST_QUIESCE,
    ST_REFUSED,
    ST_ACCESS,
    ST_HOLDOFF,
    ST_REVIVE,
    ST_PARKED
  } arb_state_t;
endpackage

// File: rtl/phy_poll_tick_window.sv
module phy_poll_tick_window #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);

  AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clear |=> !last); // R4
endmodule

// File: rtl/phy_poll_holdoff.sv
module phy_poll_holdoff #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cancel,
  input  logic tick,
  output logic expire,
  output logic busy
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD);
  localparam logic [HW-1:0] ONE  = HW'(1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= FULL;
    else if (cancel) cnt <= '0;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy   = (cnt != '0);
  assign expire = tick && (cnt == ONE) && !load && !cancel;

  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy); // R5
  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
    load |=> busy); // R6
endmodule

// File: rtl/phy_poll_arbiter.sv
module phy_poll_arbiter
  import phy_poll_pkg::*;
#(
  parameter int WAIT_LIMIT = 1000,
  parameter int HOLDOFF_MS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_req,
  input  logic       host_done,
  output logic       host_grant,
  output logic       host_err,
  output logic       poll_en,
  input  logic [1:0] poll_state,
  input  logic       ms_tick
);
  arb_state_t state, nxt;
  logic win_clear, win_last;
  logic tmr_load, tmr_cancel, tmr_expire, tmr_busy;
  logic grant_q, err_q, en_q;
  logic unit_active;

  assign unit_active = (poll_state == POLL_ACTIVE);
  assign win_clear   = !(state == ST_QUIESCE || state == ST_REVIVE);

  phy_poll_tick_window #(.LIMIT(WAIT_LIMIT)) u_window (
    .clk(clk), .rst(rst), .clear(win_clear), .tick(ms_tick), .last(win_last)
  );

  phy_poll_holdoff #(.HOLD(HOLDOFF_MS)) u_holdoff (
    .clk(clk), .rst(rst), .load(tmr_load), .cancel(tmr_cancel),
    .tick(ms_tick), .expire(tmr_expire), .busy(tmr_busy)
  );

  always_comb begin
    nxt        = state;
    tmr_load   = 1'b0;
    tmr_cancel = 1'b0;
    unique case (state)
      ST_LIVE:    if (host_req) nxt = ST_QUIESCE;
      ST_QUIESCE: if (ms_tick) begin
                    if (!unit_active) nxt = ST_ACCESS;
                    else if (win_last) nxt = ST_REFUSED;
                  end
      ST_REFUSED: if (!host_req) nxt = ST_LIVE;
      ST_ACCESS:  if (host_done) begin
                    nxt      = ST_HOLDOFF;
                    tmr_load = 1'b1;
                  end
      ST_HOLDOFF: if (host_req) begin
                    nxt        = ST_ACCESS;
                    tmr_cancel = 1'b1;
                  end else if (tmr_expire) begin
                    nxt = ST_REVIVE;
                  end
      ST_REVIVE:  if (ms_tick) begin
                    if (unit_active) nxt = ST_LIVE;
                    else if (win_last) nxt = ST_PARKED;
                  end
      ST_PARKED:  if (host_req) nxt = ST_ACCESS;
      default:    nxt = ST_LIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LIVE;
      grant_q <= 1'b0;
      err_q   <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      state   <= nxt;
      grant_q <= (nxt == ST_ACCESS);
      err_q   <= (nxt == ST_REFUSED) || (state == ST_REVIVE && nxt == ST_PARKED);
      en_q    <= (nxt == ST_LIVE) || (nxt == ST_REFUSED) || (nxt == ST_REVIVE);
    end
  end

  assign host_grant = grant_q;
  assign host_err   = err_q;
  assign poll_en    = en_q;

  AST_GRANT_UNIT_OFF: assert property (@(posedge clk) disable iff (rst)
    host_grant |-> !poll_en); // R3
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    host_grant && !host_done |=> host_grant); // R3
  AST_DONE_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    host_grant && host_done |=> !host_grant && !poll_en && tmr_busy); // R5
  AST_REFUSE_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    state == ST_QUIESCE && ms_tick && win_last && unit_active |=> host_err && !host_grant); // R4
  AST_NO_GRANT_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    !(host_grant && host_err)); // R4
  AST_FAST_REGRANT: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLDOFF && host_req |=> host_grant && !poll_en); // R6
endmodule

// File: tb/phy_poll_arbiter_tb.sv
module phy_poll_arbiter_tb;
  localparam int CLK_P = 10;
  localparam int WL = 4;
  localparam int HO = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_done = 1'b0, ms_tick = 1'b0;
  logic [1:0] poll_state = 2'b11;
  logic host_grant, host_err, poll_en;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  phy_poll_arbiter #(.WAIT_LIMIT(WL), .HOLDOFF_MS(HO)) u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_done(host_done),
    .host_grant(host_grant), .host_err(host_err), .poll_en(poll_en),
    .poll_state(poll_state), .ms_tick(ms_tick)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    cyc();
    ms_tick = 1'b0;
  endtask

  // from idle and enabled: stop handshake succeeding at first tick
  task automatic acquire();
    host_req = 1'b1;
    cyc();
    poll_state = 2'b00;
    tick();
    check("R2 grant after stop", int'(host_grant), 1);
  endtask

  task automatic release_access();
    host_done = 1'b1;
    host_req  = 1'b0;
    cyc();
    host_done = 1'b0;
    check("R5 grant drops on done", int'(host_grant), 0);
  endtask

  // run hold-off to expiry, then a successful start wait
  task automatic restart_unit();
    for (int h = 1; h <= HO; h++) begin
      tick();
      check("R5 holdoff poll_en", int'(poll_en), (h == HO) ? 1 : 0);
    end
    poll_state = 2'b11;
    tick();
    check("R7 enabled after start", int'(poll_en), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    check("R1 reset poll_en", int'(poll_en), 1);
    check("R1 reset grant", int'(host_grant), 0);
    check("R1 reset err", int'(host_err), 0);
    for (int i = 0; i < 3; i++) tick();
    check("R1 idle ticks poll_en", int'(poll_en), 1);
    check("R1 idle ticks grant", int'(host_grant), 0);

    // stop-wait sweep: unit stops at tick k (k = WL+1 means never)
    for (int k = 1; k <= WL + 1; k++) begin
      poll_state = 2'b11;
      host_req = 1'b1;
      cyc();
      check("R2 poll_en drops", int'(poll_en), 0);
      check("R2 no early grant", int'(host_grant), 0);
      for (int t = 1; t <= WL; t++) begin
        if (t == k) poll_state = 2'b01;
        tick();
        if (t >= k) begin
          check("R2 grant at stop tick", int'(host_grant), 1);
          break;
        end else if (t == WL) begin
          check("R4 refused err", int'(host_err), 1);
          check("R4 refused grant", int'(host_grant), 0);
          check("R4 refused poll_en", int'(poll_en), 1);
        end else begin
          check("R2 still waiting", int'(host_grant), 0);
        end
      end
      if (k > WL) begin
        cyc();
        check("R4 err held", int'(host_err), 1);
        host_req = 1'b0;
        cyc();
        check("R4 err clears", int'(host_err), 0);
        check("R4 back enabled", int'(poll_en), 1);
      end else begin
        for (int i = 0; i < 3; i++) cyc();
        check("R3 grant held", int'(host_grant), 1);
        check("R3 poll_en off in grant", int'(poll_en), 0);
        release_access();
        restart_unit();
      end
    end

    // hold-off cancel sweep: new request after a ticks
    for (int a = 0; a < HO; a++) begin
      acquire();
      release_access();
      for (int i = 0; i < a; i++) tick();
      check("R5 still off", int'(poll_en), 0);
      host_req = 1'b1;
      cyc();
      check("R6 fast grant", int'(host_grant), 1);
      check("R6 poll_en stays off", int'(poll_en), 0);
      for (int i = 0; i < HO + 1; i++) tick();
      check("R6 ticks in access ignored", int'(host_grant), 1);
      check("R6 poll_en off in access", int'(poll_en), 0);
      release_access();
      restart_unit();
    end

    // start-wait sweep: unit reports active at tick k (k = WL+1 means never)
    for (int k = 1; k <= WL + 1; k++) begin
      acquire();
      release_access();
      for (int h = 1; h <= HO; h++) tick();
      check("R5 revive poll_en", int'(poll_en), 1);
      for (int t = 1; t <= WL; t++) begin
        if (t == k) poll_state = 2'b11;
        tick();
        if (t >= k) begin
          check("R7 start done", int'(poll_en), 1);
          check("R7 no err", int'(host_err), 0);
          break;
        end else if (t == WL) begin
          check("R8 start timeout err", int'(host_err), 1);
          check("R8 poll_en back off", int'(poll_en), 0);
        end
      end
      if (k > WL) begin
        cyc();
        check("R8 err is a pulse", int'(host_err), 0);
        host_req = 1'b1;
        cyc();
        check("R8 parked fast grant", int'(host_grant), 1);
        release_access();
        restart_unit();
      end
    end

    // request during start wait
    acquire();
    release_access();
    for (int h = 1; h <= HO; h++) tick();
    host_req = 1'b1;
    tick();
    check("R9 no grant in start wait", int'(host_grant), 0);
    check("R9 poll_en on in start wait", int'(poll_en), 1);
    poll_state = 2'b11;
    tick();
    check("R9 enabled first", int'(poll_en), 1);
    cyc();
    check("R9 then stop handshake", int'(poll_en), 0);
    check("R9 no grant yet", int'(host_grant), 0);
    poll_state = 2'b10;
    tick();
    check("R9 granted", int'(host_grant), 1);
    release_access();
    restart_unit();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule